// File: doc/BRIEF.md
# Memory-Mapped Terminal Controller

This block is a bus-slave peripheral that gives a processor a character terminal through four word registers in a high address window. One register pair belongs to a keyboard receiver and the other to a display transmitter. Each pair has a status/control word and a data word. The processor uses a plain word-wide bus with an address, a read strobe, a write strobe, write data and combinational read data. Each channel exposes a Ready flag that software can poll. Setting a channel's interrupt-enable bit makes that same Ready flag drive a level interrupt request instead.

The side effects of the registers are what make either software style work. Reading the receiver data word empties the receiver, and writing the transmitter data word starts a character toward the display. The display is modelled as a fixed latency of `TX_LAT` cycles. The block holds one byte per direction.

The block contains two small state machines. The receiver has the states `RX_EMPTY` and `RX_HOLD`. It moves from `RX_EMPTY` to `RX_HOLD` when a keyboard byte arrives. It moves from `RX_HOLD` to `RX_EMPTY` when the data word is read and no byte arrives in the same cycle. The transmitter has the states `TX_IDLE` and `TX_SEND`. It moves from `TX_IDLE` to `TX_SEND` on a data-word write. It moves from `TX_SEND` back to `TX_IDLE` when its countdown reaches zero.

Top module: `term_io_ctrl`

## Requirements
- R1: After reset the receiver Ready bit is 0 and the transmitter Ready bit is 1. Both interrupt enables are 0, and `irq`, `disp_strobe`, `disp_busy` and `disp_byte` are 0.
- R2: The window is the 256-byte region starting at `BASE` (default 0xFFFF0000). The registers sit at these offsets: 0 is the receiver control word, 4 is the receiver data word, 8 is the transmitter control word and 12 is the transmitter data word. Any other address, inside or outside the window, reads 0 and ignores writes. The transmitter data word reads 0. `bus_rdata` is 0 whenever `bus_rd` is low.
- R3: A cycle with `kb_valid` high loads `kb_byte` into bits 7:0 of the receiver data word and sets receiver Ready (control bit 0) from the next cycle on. Bits 31:8 of the data word read 0.
- R4: A read of the receiver data word returns the held byte in the same cycle. If no byte arrives in that cycle, receiver Ready is 0 from the next cycle on.
- R5: A byte that arrives while receiver Ready is 1 overwrites the held byte, and Ready stays 1. A byte that arrives in the same cycle as a data-word read also leaves Ready at 1 and is the byte held afterwards.
- R6: A write to the transmitter data word while transmitter Ready is 1 drives `disp_strobe` high for exactly the next cycle. In that cycle `disp_byte` equals write data bits 7:0, and transmitter Ready reads 0 from that cycle on.
- R7: Transmitter Ready returns to 1 exactly `TX_LAT` cycles after the accepting write's clock edge. `disp_busy` is high exactly while transmitter Ready is 0, and `disp_byte` holds its value until the next accepted write.
- R8: A write to the transmitter data word while transmitter Ready is 0 is ignored. It produces no strobe, leaves `disp_byte` unchanged and does not restart the countdown.
- R9: Bit 1 of each control word is that channel's interrupt enable and is read/write. Bit 0 is read-only, so writes to it have no effect. Bits 31:2 read 0.
- R10: `irq` is the level (receiver enable AND receiver Ready) OR (transmitter enable AND transmitter Ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| kb_valid | input | 1 | A keyboard byte is present this cycle |
| kb_byte | input | 8 | Keyboard byte |
| disp_strobe | output | 1 | One-cycle pulse that sends a character to the display |
| disp_byte | output | 8 | Character being sent |
| disp_busy | output | 1 | Display still consuming the last character |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situations to reach from the ports are the coincidences at a single clock edge. One is a keyboard byte landing in the very cycle the processor reads the receiver data word. Another is a transmitter data write arriving while the display countdown is still running. The stimulus sets these up on purpose: it strobes `kb_valid` in the same cycle as the data read, and it issues a second write a few cycles after the first. A long stretch of random accesses then runs over the mapped and unmapped offsets while keyboard bytes arrive at random. A behavioural model checks every output on every cycle throughout.

// File: rtl/term_io_pkg.sv
package term_io_pkg;

    typedef enum logic {
        RX_EMPTY,
        RX_HOLD
    } rx_state_t;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RX_CTL,
        SEL_RX_DAT,
        SEL_TX_CTL,
        SEL_TX_DAT
    } reg_sel_t;

    localparam int CTL_RDY_BIT = 0;
    localparam int CTL_IE_BIT  = 1;

    localparam int OFS_RX_CTL = 0;
    localparam int OFS_RX_DAT = 4;
    localparam int OFS_TX_CTL = 8;
    localparam int OFS_TX_DAT = 12;

endpackage

// File: rtl/term_io_decode.sv
module term_io_decode
    import term_io_pkg::*;
#(
    parameter int              AW        = 32,
    parameter logic [AW-1:0]   BASE      = 32'hFFFF_0000,
    parameter int              WIN_BYTES = 256
) (
    input  logic [AW-1:0] addr,
    output reg_sel_t      sel
);
    localparam int WB = $clog2(WIN_BYTES);

    logic          in_win;
    logic [WB-1:0] ofs;

    assign in_win = (addr[AW-1:WB] == BASE[AW-1:WB]);
    assign ofs    = addr[WB-1:0];

    always_comb begin
        sel = SEL_NONE;
        if (in_win) begin
            if (ofs == WB'(OFS_RX_CTL))      sel = SEL_RX_CTL;
            else if (ofs == WB'(OFS_RX_DAT)) sel = SEL_RX_DAT;
            else if (ofs == WB'(OFS_TX_CTL)) sel = SEL_TX_CTL;
            else if (ofs == WB'(OFS_TX_DAT)) sel = SEL_TX_DAT;
        end
    end

endmodule

// File: rtl/term_io_rx.sv
module term_io_rx
    import term_io_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kb_valid,
    input  logic [DW-1:0] kb_byte,
    input  logic          data_rd,
    input  logic          ctl_wr,
    input  logic          wr_ie,
    output logic          ready,
    output logic          ie,
    output logic [DW-1:0] held
);
    rx_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_EMPTY: if (kb_valid) nxt = RX_HOLD;
            RX_HOLD:  if (!kb_valid && data_rd) nxt = RX_EMPTY;
            default:  nxt = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
            ie   <= 1'b0;
        end else begin
            if (kb_valid) held <= kb_byte;
            if (ctl_wr)   ie   <= wr_ie;
        end
    end

    always_comb ready = (state == RX_HOLD);

    p_arrival_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        kb_valid |=> ready && (held == $past(kb_byte)));

    p_read_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !kb_valid) |=> !ready);

    p_overwrite_keeps_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && kb_valid) |=> ready);

    p_ie_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ie == $past(wr_ie)));

endmodule

// File: rtl/term_io_tx.sv
module term_io_tx
    import term_io_pkg::*;
#(
    parameter int DW  = 8,
    parameter int LAT = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic [DW-1:0] wr_byte,
    input  logic          ctl_wr,
    input  logic          wr_ie,
    output logic          ready,
    output logic          ie,
    output logic          disp_strobe,
    output logic [DW-1:0] disp_byte,
    output logic          disp_busy
);
    localparam int CW = $clog2(LAT + 1);

    tx_state_t       state, nxt;
    logic [CW-1:0]   cnt;
    logic            accept;

    assign accept = (state == TX_IDLE) && data_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: if (data_wr) nxt = TX_SEND;
            TX_SEND: if (cnt == '0) nxt = TX_IDLE;
            default: nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            disp_strobe <= 1'b0;
            disp_byte   <= '0;
            ie          <= 1'b0;
        end else begin
            disp_strobe <= accept;
            if (accept) begin
                cnt       <= CW'(LAT - 1);
                disp_byte <= wr_byte;
            end else if (state == TX_SEND && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (ctl_wr) ie <= wr_ie;
        end
    end

    always_comb begin
        ready     = (state == TX_IDLE);
        disp_busy = (state == TX_SEND);
    end

    p_write_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && data_wr) |=> !ready && disp_strobe && (disp_byte == $past(wr_byte)));

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_strobe |=> !disp_strobe);

    p_ready_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SEND && cnt == '0) |=> ready);

    p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && data_wr) |=> !disp_strobe && $stable(disp_byte));

endmodule

// File: rtl/term_io_ctrl.sv
module term_io_ctrl
    import term_io_pkg::*;
#(
    parameter logic [31:0] BASE      = 32'hFFFF_0000,
    parameter int          WIN_BYTES = 256,
    parameter int          TX_LAT    = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        kb_valid,
    input  logic [7:0]  kb_byte,
    output logic        disp_strobe,
    output logic [7:0]  disp_byte,
    output logic        disp_busy,
    output logic        irq
);
    localparam int DW = 8;

    reg_sel_t      sel;
    logic          rx_rdy, rx_ie, tx_rdy, tx_ie;
    logic [DW-1:0] rx_held;

    term_io_decode #(.AW(32), .BASE(BASE), .WIN_BYTES(WIN_BYTES)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    term_io_rx #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .kb_valid (kb_valid),
        .kb_byte  (kb_byte),
        .data_rd  (bus_rd && sel == SEL_RX_DAT),
        .ctl_wr   (bus_wr && sel == SEL_RX_CTL),
        .wr_ie    (bus_wdata[CTL_IE_BIT]),
        .ready    (rx_rdy),
        .ie       (rx_ie),
        .held     (rx_held)
    );

    term_io_tx #(.DW(DW), .LAT(TX_LAT)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_wr     (bus_wr && sel == SEL_TX_DAT),
        .wr_byte     (bus_wdata[DW-1:0]),
        .ctl_wr      (bus_wr && sel == SEL_TX_CTL),
        .wr_ie       (bus_wdata[CTL_IE_BIT]),
        .ready       (tx_rdy),
        .ie          (tx_ie),
        .disp_strobe (disp_strobe),
        .disp_byte   (disp_byte),
        .disp_busy   (disp_busy)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_RX_CTL: begin
                    bus_rdata[CTL_RDY_BIT] = rx_rdy;
                    bus_rdata[CTL_IE_BIT]  = rx_ie;
                end
                SEL_RX_DAT: bus_rdata[DW-1:0] = rx_held;
                SEL_TX_CTL: begin
                    bus_rdata[CTL_RDY_BIT] = tx_rdy;
                    bus_rdata[CTL_IE_BIT]  = tx_ie;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    always_comb irq = (rx_ie && rx_rdy) || (tx_ie && tx_rdy);

    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    p_irq_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && rx_rdy) |-> irq);

    p_irq_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie && tx_rdy) |-> irq);

    p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq);

endmodule

// File: tb/term_io_ctrl_tb.sv
module term_io_ctrl_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          LAT        = 5;
    localparam logic [31:0] BASE       = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_byte = '0;
    logic        disp_strobe, disp_busy, irq;
    logic [7:0]  disp_byte;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit       m_rx_rdy = 0, m_rx_ie = 0, m_tx_ie = 0, m_strobe = 0;
    bit [7:0] m_rx_byte = 0, m_disp_byte = 0;
    int       m_tx_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    term_io_ctrl #(.BASE(BASE), .WIN_BYTES(256), .TX_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kb_valid(kb_valid), .kb_byte(kb_byte), .disp_strobe(disp_strobe),
        .disp_byte(disp_byte), .disp_busy(disp_busy), .irq(irq)
    );

    function automatic int ofs_of(input logic [31:0] a);
        if (a[31:8] != BASE[31:8]) return -1;
        return int'(a[7:0]);
    endfunction

    function automatic logic [31:0] exp_rdata();
        logic [31:0] r = '0;
        if (!bus_rd) return r;
        case (ofs_of(bus_addr))
            0:  r = {30'b0, m_rx_ie, m_rx_rdy};
            4:  r = {24'b0, m_rx_byte};
            8:  r = {30'b0, m_tx_ie, (m_tx_left == 0)};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int  o = ofs_of(bus_addr);
        bit  nstrobe = 0;
        if (kb_valid) begin
            m_rx_byte = kb_byte;
            m_rx_rdy  = 1;
        end else if (bus_rd && o == 4) begin
            m_rx_rdy = 0;
        end
        if (bus_wr && o == 0) m_rx_ie = bus_wdata[1];
        if (bus_wr && o == 8) m_tx_ie = bus_wdata[1];
        if (bus_wr && o == 12 && m_tx_left == 0) begin
            m_tx_left   = LAT;
            nstrobe     = 1;
            m_disp_byte = bus_wdata[7:0];
        end else if (m_tx_left > 0) begin
            m_tx_left--;
        end
        m_strobe = nstrobe;
    endtask

    // one bus cycle: drive at negedge, compare all outputs, then step the model at posedge
    task automatic step(input string req, input bit rd, input bit wr, input logic [31:0] addr,
                        input logic [31:0] wd, input bit kv, input logic [7:0] kb);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        kb_valid = kv; kb_byte = kb;
        #1;
        chk(req, "rdata", bus_rdata, exp_rdata());
        chk(req, "irq", {31'b0, irq}, {31'b0, (m_rx_ie && m_rx_rdy) || (m_tx_ie && m_tx_left == 0)});
        chk(req, "strobe", {31'b0, disp_strobe}, {31'b0, m_strobe});
        chk(req, "busy", {31'b0, disp_busy}, {31'b0, m_tx_left != 0});
        chk(req, "dbyte", {24'b0, disp_byte}, {24'b0, m_disp_byte});
        @(posedge clk);
        model_edge();
    endtask

    task automatic rd(input string req, input int o);
        step(req, 1, 0, BASE + 32'(o), '0, 0, '0);
    endtask
    task automatic wr(input string req, input int o, input logic [31:0] d);
        step(req, 0, 1, BASE + 32'(o), d, 0, '0);
    endtask
    task automatic kb(input string req, input logic [7:0] b);
        step(req, 0, 0, '0, '0, 1, b);
    endtask
    task automatic idle(input string req, input int n);
        for (int i = 0; i < n; i++) step(req, 0, 0, '0, '0, 0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd("R1", 0); rd("R1", 8); rd("R1", 4); idle("R1", 1);

        // R3 / R4: arrival, then read clears
        kb("R3", 8'h41);
        rd("R3", 0);
        rd("R4", 4);
        rd("R4", 0);
        rd("R4", 4);

        // R5: overwrite and coincident read/arrival
        kb("R5", 8'h10); kb("R5", 8'h22);
        rd("R5", 0);
        step("R5", 1, 0, BASE + 32'd4, '0, 1, 8'h33);
        rd("R5", 0); rd("R5", 4); rd("R5", 0);

        // R9: enable bit read/write, ready bit read-only
        wr("R9", 0, 32'hFFFF_FFFF); rd("R9", 0);
        wr("R9", 8, 32'h0000_0000); rd("R9", 8);
        wr("R9", 0, 32'h0000_0001); rd("R9", 0);

        // R10: interrupt level from each channel
        wr("R10", 0, 32'h2); kb("R10", 8'h5A); idle("R10", 1);
        rd("R10", 4); idle("R10", 1);
        wr("R10", 8, 32'h2); idle("R10", 1);

        // R6 / R7: transmit and latency
        wr("R6", 12, 32'h0000_01AB);
        for (int i = 0; i < LAT + 2; i++) rd("R7", 8);

        // R8: write while busy is dropped
        wr("R6", 12, 32'h0000_00C3);
        idle("R8", 2);
        wr("R8", 12, 32'h0000_0055);
        for (int i = 0; i < LAT; i++) rd("R8", 8);
        wr("R7", 8, 32'h0);

        // R2: unmapped offsets and addresses outside the window
        kb("R2", 8'h77);
        rd("R2", 16); rd("R2", 8'h80); rd("R2", 2); rd("R2", 12);
        step("R2", 1, 0, 32'hFFFE_0000, '0, 0, '0);
        step("R2", 1, 0, 32'hFFFE_0004, '0, 0, '0);
        wr("R2", 16, 32'hFFFF_FFFF); wr("R2", 8'hFC, 32'hFFFF_FFFF);
        step("R2", 0, 1, 32'h0000_000C, 32'h99, 0, '0);
        step("R2", 0, 1, 32'h0000_0000, 32'h2, 0, '0);
        rd("R2", 0); rd("R2", 8); rd("R2", 4);

        // random traffic over all offsets (R2 R3 R4 R5 R6 R7 R8 R9 R10)
        for (int i = 0; i < 400; i++) begin
            int  pick = $urandom_range(0, 5);
            int  o    = (pick < 4) ? pick * 4 : ((pick == 4) ? 20 : 1);
            bit  r    = ($urandom_range(0, 1) == 1);
            bit  w    = !r && ($urandom_range(0, 2) == 0);
            bit  k    = ($urandom_range(0, 4) == 0);
            step("R2", r, w, BASE + 32'(o), $urandom, k, 8'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule